// File: doc/BRIEF.md
# Sound Command Mailbox

This block carries one command byte at a time from a main processor to a sound processor. Both processors reach it through their own small synchronous register port (address, write data, read and write strobes, read data), clocked by one shared clock. The main side drops a byte into the mailbox with a write. The byte stays latched and a pending flag comes up. The sound side fetches the byte and then releases the mailbox by writing to an acknowledge address. Both sides can poll the pending flag.

A static mode input sets how the sound side learns of a new command. In interrupt mode every command write also raises a level interrupt request, and only the acknowledge write drops it. In polling mode the request line is left alone and the receiver watches the flag. Read data is registered. Reset is asynchronous and active low, and the block releases it internally on a clock edge.

Top module: `sound_mailbox`

## Requirements
- R1: A main-side write to address 0 stores the 8-bit write data as the command byte and sets the pending flag. Both are visible one clock later. A main-side write to any other address changes nothing.
- R2: With `irq_mode` = 1, a command write drives `snd_irq` high from the next clock. The line then stays high as a level until an acknowledge is written.
- R3: With `irq_mode` = 0, a command write updates the byte and the pending flag but leaves `snd_irq` unchanged.
- R4: A sound-side write to address 2 is an acknowledge, whatever its data. It clears the pending flag and drops `snd_irq`. A sound-side write to any other address changes nothing.
- R5: A main-side read of address 1 returns the pending flag in bit 0, with bits 7..1 zero.
- R6: A sound-side read of address 0 returns the latched command byte. Reading it does not clear the pending flag.
- R7: A sound-side read of address 1 returns the pending flag in bit 0, with bits 7..1 zero.
- R8: A command written while the flag is still pending replaces the byte, and the flag stays set.
- R9: When a command write and an acknowledge fall in the same clock, the command wins. The new byte is stored, the flag ends at 1, and in interrupt mode `snd_irq` stays high.
- R10: Reset clears the command byte, the pending flag, `snd_irq` and both read data outputs.
- R11: Read data is registered. It shows the value selected by a read strobe on the clock after the strobe. It is zero after any clock without a read strobe and after a read of an unmapped address.
- R12: `snd_irq` is never high while the pending flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_mode | input | 1 | 1: command writes raise the interrupt; 0: receiver polls |
| m_addr | input | AW | Main-side register address |
| m_wdata | input | DW | Main-side write data |
| m_wr | input | 1 | Main-side write strobe |
| m_rd | input | 1 | Main-side read strobe |
| m_rdata | output | DW | Main-side registered read data |
| s_addr | input | AW | Sound-side register address |
| s_wdata | input | DW | Sound-side write data (ignored by the acknowledge) |
| s_wr | input | 1 | Sound-side write strobe |
| s_rd | input | 1 | Sound-side read strobe |
| s_rdata | output | DW | Sound-side registered read data |
| snd_irq | output | 1 | Level interrupt request toward the sound side |

## Verification
A wrong command byte is visible on the sound side's next read of address 0. That read returns its data one clock after the strobe. A pending flag that is stuck or wrongly cleared shows on either status read within two clocks. It also shows on `snd_irq`, which must change on the clock right after a command or acknowledge write. The bench runs every one of the 256 byte values through a full write, read and acknowledge cycle in both modes. It then drives the overwrite case, the same-clock collision case, unmapped addresses and a mid-run reset. Each result is compared against a small arithmetic model of byte, flag and interrupt.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_BYTE = 2'd1,
    RSEL_FLAG = 2'd2
  } rsel_e;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_cmd_reg.sv
module mbx_cmd_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [DW-1:0] wdata,
  input  logic          ack,
  output logic [DW-1:0] byte_q,
  output logic          pend_q
);
  logic [DW-1:0] byte_d;
  logic          pend_d;
  logic          byte_en;

  assign byte_en = cmd_we;

  always_comb begin
    byte_d = byte_q;
    pend_d = pend_q;
    if (byte_en) byte_d = wdata;
    if (cmd_we)   pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (byte_en) byte_q <= byte_d;
      pend_q <= pend_d;
    end
  end

  // R1
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (pend_q && byte_q == $past(wdata)));
  // R4
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cmd_we) |=> !pend_q);
  // R6
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(byte_q));
endmodule

// File: rtl/mbx_irq_ctl.sv
module mbx_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_mode,
  input  logic cmd_we,
  input  logic ack,
  output logic irq_q
);
  logic irq_d;
  logic raise;

  assign raise = cmd_we && irq_mode;

  always_comb begin
    irq_d = irq_q;
    if (raise)    irq_d = 1'b1;
    else if (ack) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R2
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && irq_mode) |=> irq_q);
  // R3
  irq_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !irq_mode && !ack) |=> $stable(irq_q));
  // R4
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(cmd_we && irq_mode)) |=> !irq_q);
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
  parameter int              AW        = 4,
  parameter int              DW        = 8,
  parameter logic [AW-1:0]   BYTE_ADDR = '0,
  parameter logic [AW-1:0]   FLAG_ADDR = '0,
  parameter bit              HAS_BYTE  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] byte_i,
  input  logic          flag_i,
  output logic [DW-1:0] rdata
);
  import mbx_pkg::*;

  localparam int PAD_W = DW - 1;

  logic          byte_hit;
  rsel_e         sel;
  logic [DW-1:0] rdata_d;

  generate
    if (HAS_BYTE) begin : g_byte
      assign byte_hit = (addr == BYTE_ADDR);
    end else begin : g_nobyte
      assign byte_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    sel = RSEL_NONE;
    if (rd && addr == FLAG_ADDR) sel = RSEL_FLAG;
    else if (rd && byte_hit)     sel = RSEL_BYTE;
  end

  always_comb begin
    case (sel)
      RSEL_FLAG: rdata_d = {{PAD_W{1'b0}}, flag_i};
      RSEL_BYTE: rdata_d = byte_i;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == '0));
  // R5
  flag_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == FLAG_ADDR) |=> (rdata[DW-1:1] == '0 && rdata[0] == $past(flag_i)));
endmodule

// File: rtl/sound_mailbox.sv
module sound_mailbox #(
  parameter int            AW            = 4,
  parameter int            DW            = 8,
  parameter logic [AW-1:0] MAIN_CMD_ADDR = 4'd0,
  parameter logic [AW-1:0] MAIN_FLG_ADDR = 4'd1,
  parameter logic [AW-1:0] SND_CMD_ADDR  = 4'd0,
  parameter logic [AW-1:0] SND_FLG_ADDR  = 4'd1,
  parameter logic [AW-1:0] SND_ACK_ADDR  = 4'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_mode,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic          m_wr,
  input  logic          m_rd,
  output logic [DW-1:0] m_rdata,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  input  logic          s_wr,
  input  logic          s_rd,
  output logic [DW-1:0] s_rdata,
  output logic          snd_irq
);
  logic          rst_i_n;
  logic          cmd_we;
  logic          ack;
  logic [DW-1:0] byte_q;
  logic          pend_q;
  logic [DW-1:0] s_wdata_unused;

  assign s_wdata_unused = s_wdata;
  assign cmd_we = m_wr && (m_addr == MAIN_CMD_ADDR);
  assign ack    = s_wr && (s_addr == SND_ACK_ADDR);

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  mbx_cmd_reg #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_i_n), .cmd_we(cmd_we), .wdata(m_wdata),
    .ack(ack), .byte_q(byte_q), .pend_q(pend_q)
  );

  mbx_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_i_n), .irq_mode(irq_mode), .cmd_we(cmd_we),
    .ack(ack), .irq_q(snd_irq)
  );

  mbx_rd_port #(
    .AW(AW), .DW(DW), .BYTE_ADDR(MAIN_CMD_ADDR), .FLAG_ADDR(MAIN_FLG_ADDR), .HAS_BYTE(1'b0)
  ) u_mrd (
    .clk(clk), .rst_n(rst_i_n), .rd(m_rd), .addr(m_addr),
    .byte_i(byte_q), .flag_i(pend_q), .rdata(m_rdata)
  );

  mbx_rd_port #(
    .AW(AW), .DW(DW), .BYTE_ADDR(SND_CMD_ADDR), .FLAG_ADDR(SND_FLG_ADDR), .HAS_BYTE(1'b1)
  ) u_srd (
    .clk(clk), .rst_n(rst_i_n), .rd(s_rd), .addr(s_addr),
    .byte_i(byte_q), .flag_i(pend_q), .rdata(s_rdata)
  );

  // R12
  irq_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    snd_irq |-> pend_q);
  // R9
  collide_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_we && ack && irq_mode) |=> (snd_irq && pend_q));
endmodule

// File: tb/sim_sound_mailbox.sv
module sim_sound_mailbox;
  logic       clk;
  logic       rst_n;
  logic       irq_mode;
  logic [3:0] m_addr, s_addr;
  logic [7:0] m_wdata, s_wdata;
  logic       m_wr, m_rd, s_wr, s_rd;
  logic [7:0] m_rdata, s_rdata;
  logic       snd_irq;

  int total;
  int fails;
  bit done;

  sound_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_wr(m_wr), .m_rd(m_rd), .m_rdata(m_rdata),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_wr(s_wr), .s_rd(s_rd), .s_rdata(s_rdata),
    .snd_irq(snd_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); m_addr = a; m_wdata = d; m_wr = 1'b1;
    @(negedge clk); m_wr = 1'b0;
  endtask

  task automatic s_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); s_addr = a; s_wdata = d; s_wr = 1'b1;
    @(negedge clk); s_wr = 1'b0;
  endtask

  task automatic m_read(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); m_addr = a; m_rd = 1'b1;
    @(negedge clk); m_rd = 1'b0; v = m_rdata;
  endtask

  task automatic s_read(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); s_addr = a; s_rd = 1'b1;
    @(negedge clk); s_rd = 1'b0; v = s_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    total = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; irq_mode = 1'b1;
    m_addr = '0; s_addr = '0; m_wdata = '0; s_wdata = '0;
    m_wr = 0; m_rd = 0; s_wr = 0; s_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 irq", {7'd0, snd_irq}, 8'h00);
    chk("R10 m_rdata", m_rdata, 8'h00);
    chk("R10 s_rdata", s_rdata, 8'h00);
    s_read(4'd0, v); chk("R10 byte", v, 8'h00);
    m_read(4'd1, v); chk("R10 flag", v, 8'h00);

    // Exhaustive sweep, both modes
    for (int md = 0; md < 2; md++) begin
      irq_mode = md[0];
      for (int b = 0; b < 256; b++) begin
        m_write(4'd0, b[7:0]);
        chk(md ? "R2 irq raised" : "R3 irq untouched", {7'd0, snd_irq}, {7'd0, md[0]});
        repeat (2) @(negedge clk);
        chk(md ? "R2 level held" : "R3 irq still low", {7'd0, snd_irq}, {7'd0, md[0]});
        s_read(4'd0, v); chk("R6 byte", v, b[7:0]);
        @(negedge clk); chk("R11 idle zero", s_rdata, 8'h00);
        s_read(4'd1, v); chk("R7 flag after byte read", v, 8'h01);
        m_read(4'd1, v); chk("R5 flag", v, 8'h01);
        s_write(4'd2, ~b[7:0]);
        chk("R4 irq dropped", {7'd0, snd_irq}, 8'h00);
        m_read(4'd1, v); chk("R4 flag cleared", v, 8'h00);
      end
    end

    // R1 write to unmapped main address ignored
    irq_mode = 1'b1;
    m_write(4'd0, 8'h3C);
    s_write(4'd2, 8'h00);
    m_write(4'd5, 8'hC3);
    chk("R1 unmapped write irq", {7'd0, snd_irq}, 8'h00);
    s_read(4'd0, v); chk("R1 unmapped write byte", v, 8'h3C);
    s_read(4'd1, v); chk("R1 unmapped write flag", v, 8'h00);

    // R11 unmapped read returns zero
    m_read(4'd7, v); chk("R11 unmapped main read", v, 8'h00);
    s_read(4'd9, v); chk("R11 unmapped sound read", v, 8'h00);
    m_read(4'd0, v); chk("R11 main byte address not readable", v, 8'h00);

    // R8 overwrite while pending
    m_write(4'd0, 8'hA5);
    m_write(4'd0, 8'h5A);
    s_read(4'd0, v); chk("R8 overwrite byte", v, 8'h5A);
    s_read(4'd1, v); chk("R8 flag stays", v, 8'h01);
    chk("R8 irq stays", {7'd0, snd_irq}, 8'h01);

    // R4 sound write to non-ack address ignored
    s_write(4'd1, 8'hFF);
    m_read(4'd1, v); chk("R4 non-ack write keeps flag", v, 8'h01);
    chk("R4 non-ack write keeps irq", {7'd0, snd_irq}, 8'h01);

    // R9 collision, interrupt mode
    @(negedge clk);
    m_addr = 4'd0; m_wdata = 8'h77; m_wr = 1'b1;
    s_addr = 4'd2; s_wdata = 8'h00; s_wr = 1'b1;
    @(negedge clk); m_wr = 1'b0; s_wr = 1'b0;
    chk("R9 irq kept", {7'd0, snd_irq}, 8'h01);
    s_read(4'd0, v); chk("R9 byte", v, 8'h77);
    m_read(4'd1, v); chk("R9 flag", v, 8'h01);

    // R9 collision, polling mode: flag wins, ack drops irq
    irq_mode = 1'b0;
    @(negedge clk);
    m_addr = 4'd0; m_wdata = 8'h12; m_wr = 1'b1;
    s_addr = 4'd2; s_wr = 1'b1;
    @(negedge clk); m_wr = 1'b0; s_wr = 1'b0;
    chk("R9 poll irq", {7'd0, snd_irq}, 8'h00);
    s_read(4'd1, v); chk("R9 poll flag", v, 8'h01);
    s_read(4'd0, v); chk("R9 poll byte", v, 8'h12);

    // R12 polling then flag with irq low
    chk("R12 irq low with flag", {7'd0, snd_irq}, 8'h00);

    // R10 reset mid-run
    irq_mode = 1'b1;
    m_write(4'd0, 8'hEE);
    do_reset();
    chk("R10 irq after reset", {7'd0, snd_irq}, 8'h00);
    s_read(4'd0, v); chk("R10 byte after reset", v, 8'h00);
    s_read(4'd1, v); chk("R10 flag after reset", v, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule